// File: doc/BRIEF.md
# FS/GS Segment Base Register Unit

This block keeps the hidden base addresses behind the two general-purpose segment registers that a processor core uses for thread-local and per-CPU data: a base for FS, a base for GS, and a shadow kernel GS base. Each base is a 64-bit register. Software reaches the three registers through a model-specific-register interface: it reads and writes them by a 32-bit index, and the write data arrives as two 32-bit halves.

The core changes the bases in two other ways. A segment selector load into FS or GS passes in the fetched 8-byte descriptor. The block assembles the 32-bit base from the scattered fields of that descriptor and writes it into the low half of the chosen base. A privileged swap command exchanges the GS base with the kernel GS base in one cycle. The block always presents the effective base for FS and GS to the address-generation logic. In 64-bit mode that base is the full register. In compatibility mode it is the low 32 bits, zero-extended.

Descriptor table walking, fault delivery and address translation are handled elsewhere. Errors are reported only as single-cycle flags.

Top module: `seg_base_unit`

## Requirements
- R1: An MSR write loads all 64 bits of the selected base as {msr_wdata_hi, msr_wdata_lo}. Index 0xC0000100 selects FS, index 0xC0000101 selects GS and index 0xC0000102 selects the kernel GS base.
- R2: An MSR read of a supported index raises msr_rd_valid in the following cycle and returns the full 64-bit stored value on msr_rdata. This holds whatever the value of long_mode.
- R3: An MSR read or write to any other index changes no base. It pulses msr_idx_err high for exactly the following cycle, and it leaves msr_rd_valid low and msr_rdata zero.
- R4: A selector load (sel_ld_seg 0 = FS, 1 = GS) writes only bits 31:0 of that base. Bits 63:32 keep their value.
- R5: The base loaded by a selector load is assembled from the descriptor as follows: bits 15:0 come from descriptor bits 31:16, bits 23:16 from descriptor bits 39:32, and bits 31:24 from descriptor bits 63:56.
- R6: With long_mode = 1, fs_eff_base and gs_eff_base carry the full stored base. With long_mode = 0 they carry the low 32 bits zero-extended.
- R7: A swap request with cpl = 0 and long_mode = 1 exchanges the GS base and the kernel GS base at the next clock edge.
- R8: A swap request with cpl != 0 or long_mode = 0 changes no base and pulses swap_err high for the following cycle.
- R9: A synchronous reset clears all three bases, msr_rdata, msr_rd_valid and both error flags to zero.
- R10: If an MSR write or a selector load occurs in the same cycle as a swap request, the swap is dropped: no exchange and no swap_err. If an MSR write and a selector load target the same base in one cycle, the MSR write wins.
- R11: An MSR read issued in the same cycle as a write to the same base returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| msr_rd_en | input | 1 | MSR read request |
| msr_wr_en | input | 1 | MSR write request |
| msr_index | input | 32 | MSR index for read and write |
| msr_wdata_lo | input | 32 | Write data, bits 31:0 |
| msr_wdata_hi | input | 32 | Write data, bits 63:32 |
| msr_rdata | output | 64 | Registered read data |
| msr_rd_valid | output | 1 | Read data valid, one cycle after a supported read |
| msr_idx_err | output | 1 | Unsupported index pulse |
| sel_ld_en | input | 1 | Selector load event |
| sel_ld_seg | input | 1 | Selector load target: 0 FS, 1 GS |
| sel_desc | input | 64 | Fetched 8-byte descriptor |
| swap_req | input | 1 | GS/kernel GS swap command |
| cpl | input | 2 | Current privilege ring |
| long_mode | input | 1 | 1 = 64-bit mode, 0 = compatibility mode |
| swap_err | output | 1 | Rejected swap pulse |
| fs_eff_base | output | 64 | Effective FS base for address generation |
| gs_eff_base | output | 64 | Effective GS base for address generation |

## Verification
A swap can arrive in the same cycle as an MSR write or a selector load. Each of these updates the GS base. The bench drives a privileged swap together with a GS write, and a privileged swap together with a selector load. It then checks that gs_eff_base shows only the written value, that the kernel base read back is unchanged, and that swap_err stays low. A read issued in the same cycle as a write to the same index is also checked: the read must return the old value while the effective base moves to the new one.

// File: rtl/seg_base_pkg.sv
package seg_base_pkg;
  localparam int BASE_W   = 64;
  localparam int HALF_W   = 32;
  localparam int IDX_W    = 32;
  localparam int DESC_W   = 64;
  localparam int NSLOT    = 3;
  localparam int NSEG     = 2;

  localparam int SLOT_FS  = 0;
  localparam int SLOT_GS  = 1;
  localparam int SLOT_KGS = 2;

  localparam logic [IDX_W-1:0] IDX_FS  = 32'hC000_0100;
  localparam logic [IDX_W-1:0] IDX_GS  = 32'hC000_0101;
  localparam logic [IDX_W-1:0] IDX_KGS = 32'hC000_0102;

  typedef logic [BASE_W-1:0] base_t;
  typedef logic [NSLOT-1:0]  slot_oh_t;

  // Map an MSR index to a one-hot slot vector (all zero when unsupported).
  function automatic slot_oh_t idx_to_slot(input logic [IDX_W-1:0] idx);
    slot_oh_t oh;
    oh = '0;
    oh[SLOT_FS]  = (idx == IDX_FS);
    oh[SLOT_GS]  = (idx == IDX_GS);
    oh[SLOT_KGS] = (idx == IDX_KGS);
    return oh;
  endfunction

  // Gather the three scattered base fields of a segment descriptor.
  function automatic logic [HALF_W-1:0] desc_base32(input logic [DESC_W-1:0] d);
    logic [HALF_W-1:0] b;
    b[15:0]  = d[31:16];
    b[23:16] = d[39:32];
    b[31:24] = d[63:56];
    return b;
  endfunction

  // Base seen by address generation in the current mode.
  function automatic base_t mode_base(input base_t b, input logic wide);
    return wide ? b : {{(BASE_W-HALF_W){1'b0}}, b[HALF_W-1:0]};
  endfunction
endpackage

// File: rtl/sbu_msr_decode.sv
module sbu_msr_decode
  import seg_base_pkg::*;
(
  input  logic [IDX_W-1:0] index,
  output slot_oh_t         slot_oh,
  output logic             idx_ok
);
  always_comb begin
    slot_oh = idx_to_slot(index);
    idx_ok  = |slot_oh;
  end
endmodule

// File: rtl/sbu_desc_extract.sv
module sbu_desc_extract
  import seg_base_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output logic [HALF_W-1:0] base_lo
);
  logic unused_desc_bits;
  assign unused_desc_bits = ^{desc[55:40], desc[15:0]};
  assign base_lo = desc_base32(desc);
endmodule

// File: rtl/sbu_eff_base.sv
module sbu_eff_base
  import seg_base_pkg::*;
(
  input  base_t stored,
  input  logic  wide_mode,
  output base_t eff
);
  assign eff = mode_base(stored, wide_mode);
endmodule

// File: rtl/sbu_base_bank.sv
module sbu_base_bank
  import seg_base_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  slot_oh_t          wr_oh,
  input  base_t             wr_data,
  input  logic              ld_en,
  input  logic              ld_seg,
  input  logic [HALF_W-1:0] ld_base,
  input  logic              swap_fire,
  input  logic              rd_en,
  input  slot_oh_t          rd_oh,
  output base_t             rdata_q,
  output logic              rd_valid_q,
  output base_t             slot_q [NSLOT]
);
  base_t slot_nxt [NSLOT];

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic ld_hit;
    if (k == SLOT_FS) begin : g_fs
      assign ld_hit = ld_en && !ld_seg;
    end else if (k == SLOT_GS) begin : g_gs
      assign ld_hit = ld_en && ld_seg;
    end else begin : g_none
      assign ld_hit = 1'b0;
    end

    base_t swap_src;
    if (k == SLOT_GS) begin : g_sw_gs
      assign swap_src = slot_q[SLOT_KGS];
    end else if (k == SLOT_KGS) begin : g_sw_kgs
      assign swap_src = slot_q[SLOT_GS];
    end else begin : g_sw_none
      assign swap_src = slot_q[k];
    end

    always_comb begin
      slot_nxt[k] = slot_q[k];
      if (ld_hit)
        slot_nxt[k][HALF_W-1:0] = ld_base;
      if (wr_en && wr_oh[k])
        slot_nxt[k] = wr_data;
      if (swap_fire)
        slot_nxt[k] = swap_src;
    end

    always_ff @(posedge clk) begin
      if (rst) slot_q[k] <= '0;
      else     slot_q[k] <= slot_nxt[k];
    end
  end

  base_t rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NSLOT; k++)
      if (rd_oh[k]) rd_mux = slot_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en && (|rd_oh);
      rdata_q    <= (rd_en && (|rd_oh)) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/seg_base_unit.sv
module seg_base_unit
  import seg_base_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              msr_rd_en,
  input  logic              msr_wr_en,
  input  logic [IDX_W-1:0]  msr_index,
  input  logic [HALF_W-1:0] msr_wdata_lo,
  input  logic [HALF_W-1:0] msr_wdata_hi,
  output logic [BASE_W-1:0] msr_rdata,
  output logic              msr_rd_valid,
  output logic              msr_idx_err,
  input  logic              sel_ld_en,
  input  logic              sel_ld_seg,
  input  logic [DESC_W-1:0] sel_desc,
  input  logic              swap_req,
  input  logic [1:0]        cpl,
  input  logic              long_mode,
  output logic              swap_err,
  output logic [BASE_W-1:0] fs_eff_base,
  output logic [BASE_W-1:0] gs_eff_base
);
  slot_oh_t          idx_oh;
  logic              idx_ok;
  logic [HALF_W-1:0] ld_base;
  base_t             slot_q [NSLOT];
  base_t             fs_q, gs_q, kgs_q;

  // Named internal events for the checker.
  logic wr_any, bad_access, priv_ok, swap_fire, swap_reject;

  assign wr_any      = msr_wr_en || sel_ld_en;
  assign bad_access  = (msr_rd_en || msr_wr_en) && !idx_ok;
  assign priv_ok     = (cpl == 2'd0) && long_mode;
  assign swap_fire   = swap_req && !wr_any && priv_ok;
  assign swap_reject = swap_req && !wr_any && !priv_ok;

  sbu_msr_decode u_dec (
    .index   (msr_index),
    .slot_oh (idx_oh),
    .idx_ok  (idx_ok)
  );

  sbu_desc_extract u_desc (
    .desc    (sel_desc),
    .base_lo (ld_base)
  );

  sbu_base_bank u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (msr_wr_en),
    .wr_oh      (idx_oh),
    .wr_data    ({msr_wdata_hi, msr_wdata_lo}),
    .ld_en      (sel_ld_en),
    .ld_seg     (sel_ld_seg),
    .ld_base    (ld_base),
    .swap_fire  (swap_fire),
    .rd_en      (msr_rd_en),
    .rd_oh      (idx_oh),
    .rdata_q    (msr_rdata),
    .rd_valid_q (msr_rd_valid),
    .slot_q     (slot_q)
  );

  assign fs_q  = slot_q[SLOT_FS];
  assign gs_q  = slot_q[SLOT_GS];
  assign kgs_q = slot_q[SLOT_KGS];

  base_t seg_stored [NSEG];
  base_t seg_eff    [NSEG];
  assign seg_stored[0] = fs_q;
  assign seg_stored[1] = gs_q;

  for (genvar g = 0; g < NSEG; g++) begin : g_eff
    sbu_eff_base u_eff (
      .stored    (seg_stored[g]),
      .wide_mode (long_mode),
      .eff       (seg_eff[g])
    );
  end

  assign fs_eff_base = seg_eff[0];
  assign gs_eff_base = seg_eff[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      msr_idx_err <= 1'b0;
      swap_err    <= 1'b0;
    end else begin
      msr_idx_err <= bad_access;
      swap_err    <= swap_reject;
    end
  end
endmodule

// File: rtl/sbu_checker.sv
module sbu_checker
  import seg_base_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        msr_wr_en,
  input logic        sel_ld_en,
  input logic        sel_ld_seg,
  input logic        swap_req,
  input logic        long_mode,
  input logic        msr_idx_err,
  input logic        msr_rd_valid,
  input logic        swap_err,
  input logic        bad_access,
  input logic        wr_any,
  input logic        priv_ok,
  input logic        swap_fire,
  input base_t       fs_q,
  input base_t       gs_q,
  input base_t       kgs_q,
  input base_t       fs_eff_base,
  input base_t       gs_eff_base
);
  p_idx_err_r3: assert property (@(posedge clk) disable iff (rst)
    bad_access |=> (msr_idx_err && !msr_rd_valid));

  p_idx_err_only_r3: assert property (@(posedge clk) disable iff (rst)
    !bad_access |=> !msr_idx_err);

  p_bad_write_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (bad_access && !sel_ld_en && !swap_fire) |=>
      (fs_q == $past(fs_q) && gs_q == $past(gs_q) && kgs_q == $past(kgs_q)));

  p_sel_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_ld_en && !msr_wr_en && !sel_ld_seg) |=> (fs_q[63:32] == $past(fs_q[63:32])));

  p_compat_zext_r6: assert property (@(posedge clk) disable iff (rst)
    !long_mode |-> (fs_eff_base[63:32] == '0 && gs_eff_base[63:32] == '0));

  p_swap_exch_r7: assert property (@(posedge clk) disable iff (rst)
    swap_fire |=> (gs_q == $past(kgs_q) && kgs_q == $past(gs_q)));

  p_swap_rej_r8: assert property (@(posedge clk) disable iff (rst)
    (swap_req && !wr_any && !priv_ok) |=>
      (swap_err && gs_q == $past(gs_q) && kgs_q == $past(kgs_q)));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (fs_q == '0 && gs_q == '0 && kgs_q == '0 && !swap_err && !msr_idx_err));

  p_swap_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (swap_req && wr_any) |=> (!swap_err && kgs_q == $past(kgs_q) || msr_wr_en == 1'b1 && $past(msr_wr_en)));
endmodule

bind seg_base_unit sbu_checker u_sbu_checker (
  .clk          (clk),
  .rst          (rst),
  .msr_wr_en    (msr_wr_en),
  .sel_ld_en    (sel_ld_en),
  .sel_ld_seg   (sel_ld_seg),
  .swap_req     (swap_req),
  .long_mode    (long_mode),
  .msr_idx_err  (msr_idx_err),
  .msr_rd_valid (msr_rd_valid),
  .swap_err     (swap_err),
  .bad_access   (bad_access),
  .wr_any       (wr_any),
  .priv_ok      (priv_ok),
  .swap_fire    (swap_fire),
  .fs_q         (fs_q),
  .gs_q         (gs_q),
  .kgs_q        (kgs_q),
  .fs_eff_base  (fs_eff_base),
  .gs_eff_base  (gs_eff_base)
);

// File: tb/test_seg_base_unit.sv
module test_seg_base_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst;
  logic        msr_rd_en, msr_wr_en;
  logic [31:0] msr_index, msr_wdata_lo, msr_wdata_hi;
  logic [63:0] msr_rdata;
  logic        msr_rd_valid, msr_idx_err;
  logic        sel_ld_en, sel_ld_seg;
  logic [63:0] sel_desc;
  logic        swap_req;
  logic [1:0]  cpl;
  logic        long_mode;
  logic        swap_err;
  logic [63:0] fs_eff_base, gs_eff_base;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_base_unit i_seg_base_unit (.*);

  typedef struct {
    logic        rd_valid;
    logic [63:0] rdata;
    logic        idx_err;
    logic        sw_err;
    logic [63:0] fs_eff;
    logic [63:0] gs_eff;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench-side model of the three bases: [0] FS, [1] GS, [2] kernel GS.
  logic [63:0] m_base [3];

  function automatic int slot_of(input logic [31:0] idx);
    case (idx)
      32'hC000_0100: return 0;
      32'hC000_0101: return 1;
      32'hC000_0102: return 2;
      default:       return -1;
    endcase
  endfunction

  function automatic logic [31:0] model_desc(input logic [63:0] d);
    return {d[63:56], d[39:32], d[31:16]};
  endfunction

  function automatic logic [63:0] model_view(input logic [63:0] b, input logic lm);
    if (lm) return b;
    return {32'h0, b[31:0]};
  endfunction

  task automatic idle_inputs();
    msr_rd_en = 0; msr_wr_en = 0; msr_index = 0;
    msr_wdata_lo = 0; msr_wdata_hi = 0;
    sel_ld_en = 0; sel_ld_seg = 0; sel_desc = 0; swap_req = 0;
  endtask

  // Driver: inputs are already set; compute expectations and push one item.
  task automatic step(input string tag);
    exp_t e;
    int s;
    bit w_any;
    s = slot_of(msr_index);
    w_any = msr_wr_en || sel_ld_en;
    e.tag = tag;
    if (rst) begin
      foreach (m_base[k]) m_base[k] = 64'h0;
      e.rd_valid = 0; e.rdata = 0; e.idx_err = 0; e.sw_err = 0;
    end else begin
      e.rd_valid = msr_rd_en && (s >= 0);
      e.rdata    = (msr_rd_en && s >= 0) ? m_base[s] : 64'h0;
      e.idx_err  = (msr_rd_en || msr_wr_en) && (s < 0);
      e.sw_err   = swap_req && !w_any && !(cpl == 0 && long_mode);
      if (sel_ld_en) m_base[sel_ld_seg ? 1 : 0][31:0] = model_desc(sel_desc);
      if (msr_wr_en && s >= 0) m_base[s] = {msr_wdata_hi, msr_wdata_lo};
      if (swap_req && !w_any && cpl == 0 && long_mode) begin
        logic [63:0] t;
        t = m_base[1]; m_base[1] = m_base[2]; m_base[2] = t;
      end
    end
    e.fs_eff = model_view(m_base[0], long_mode);
    e.gs_eff = model_view(m_base[1], long_mode);
    exp_q.push_back(e);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic cmp64(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: after each edge, pop and compare.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp64(e.tag, "rd_valid", {63'h0, msr_rd_valid}, {63'h0, e.rd_valid});
        cmp64(e.tag, "rdata",    msr_rdata, e.rdata);
        cmp64(e.tag, "idx_err",  {63'h0, msr_idx_err}, {63'h0, e.idx_err});
        cmp64(e.tag, "swap_err", {63'h0, swap_err}, {63'h0, e.sw_err});
        cmp64(e.tag, "fs_eff",   fs_eff_base, e.fs_eff);
        cmp64(e.tag, "gs_eff",   gs_eff_base, e.gs_eff);
      end
    end
  end

  task automatic msr_wr(input logic [31:0] idx, input logic [63:0] v, input string tag);
    msr_wr_en = 1; msr_index = idx; msr_wdata_lo = v[31:0]; msr_wdata_hi = v[63:32];
    step(tag);
  endtask

  task automatic msr_rd(input logic [31:0] idx, input string tag);
    msr_rd_en = 1; msr_index = idx;
    step(tag);
  endtask

  task automatic sel_ld(input logic seg, input logic [63:0] d, input string tag);
    sel_ld_en = 1; sel_ld_seg = seg; sel_desc = d;
    step(tag);
  endtask

  initial begin
    rst = 1; cpl = 0; long_mode = 1;
    idle_inputs();
    foreach (m_base[k]) m_base[k] = 64'hx;
    @(negedge clk);
    step("R9 reset");
    step("R9 reset");
    rst = 0;
    step("R9 idle after reset");

    msr_wr(32'hC000_0100, 64'h1122_3344_5566_7788, "R1 write FS");
    msr_wr(32'hC000_0101, 64'h99AA_BBCC_DDEE_FF00, "R1 write GS");
    msr_wr(32'hC000_0102, 64'hFFFF_8000_0000_1000, "R1 write KGS");
    msr_rd(32'hC000_0100, "R2 read FS");
    msr_rd(32'hC000_0102, "R2 read KGS");

    long_mode = 0;
    step("R6 compat view");
    msr_rd(32'hC000_0101, "R2 read GS compat");
    long_mode = 1;

    sel_ld(0, 64'hAB_CF9A_12_3456_FFFF, "R4 R5 sel load FS");
    sel_ld(1, 64'h00_4F92_FE_0000_0000, "R4 R5 sel load GS");
    msr_rd(32'hC000_0100, "R4 read FS upper kept");

    msr_wr(32'hC000_0103, 64'hDEAD_BEEF_DEAD_BEEF, "R3 bad write");
    msr_rd(32'h0000_0100, "R3 bad read");
    msr_rd(32'hC000_0100, "R3 FS unchanged");

    swap_req = 1; cpl = 0;
    step("R7 swap");
    msr_rd(32'hC000_0102, "R7 read KGS after swap");

    swap_req = 1; cpl = 3;
    step("R8 swap ring3");
    cpl = 0; long_mode = 0; swap_req = 1;
    step("R8 swap compat");
    long_mode = 1;
    msr_rd(32'hC000_0101, "R8 GS unchanged");

    swap_req = 1; msr_wr_en = 1; msr_index = 32'hC000_0101;
    msr_wdata_lo = 32'h1357_9BDF; msr_wdata_hi = 32'h2468_ACE0;
    step("R10 write vs swap");
    swap_req = 1; cpl = 2; sel_ld_en = 1; sel_ld_seg = 1; sel_desc = 64'h77_0000_66_5555_0000;
    step("R10 load vs swap no err");
    cpl = 0;
    msr_rd(32'hC000_0102, "R10 KGS unchanged");
    sel_ld_en = 1; sel_ld_seg = 0; sel_desc = 64'h12_0000_34_5678_0000;
    msr_wr_en = 1; msr_index = 32'hC000_0100; msr_wdata_lo = 32'hAAAA_5555; msr_wdata_hi = 32'h0F0F_F0F0;
    step("R10 write beats load");

    msr_rd_en = 1; msr_wr_en = 1; msr_index = 32'hC000_0102;
    msr_wdata_lo = 32'h0000_0042; msr_wdata_hi = 32'h0000_0001;
    step("R11 read during write");
    msr_rd(32'hC000_0102, "R11 new value");

    rst = 1;
    step("R9 mid reset");
    rst = 0;
    msr_rd(32'hC000_0101, "R9 GS cleared");
    msr_rd(32'hC000_0102, "R9 KGS cleared");
    step("drain");
    step("drain");
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < WATCHDOG) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule